// File: doc/BRIEF.md
# SHA-1 Block Hashing Engine with Memory Fetch

This engine computes the SHA-1 compression function over a run of 64-byte message blocks that sit in memory. Software first sets up the job through a small register window: a start address and the five 32-bit chaining words, which may be the standard initial values or a state saved from earlier work. A command word then starts the engine. The engine fetches each block as sixteen 32-bit reads on a single-request memory port. It runs the 80 rounds at one round per clock and folds the result back into the chaining words. When the last block is done, busy drops.

The address register moves forward with every word the engine fetches. The chaining words stay readable at the offsets used to load them. A message longer than one command allows can therefore be hashed in pieces: software issues another command without reloading anything. Padding, the length field and the final digest formatting belong to software.

Top module: `sha1_dma`

## Requirements
- R1: After reset, status (offset 0x00) reads 0, the address register (offset 0x04) reads 0, and the chaining registers at 0x08, 0x0C, 0x10, 0x14, 0x18 read 0x67452301, 0xEFCDAB89, 0x98BADCFE, 0x10325476, 0xC3D2E1F0.
- R2: Writing offset 0x00 with bit 31 set while idle starts a job, and status bit 31 reads 1 from the next cycle until the job ends; the memory request is asserted only while busy.
- R3: The low CNT_W bits of the start command hold the block count minus one (0x1F gives 32 blocks, 0xFF gives 256). Each block is fetched as exactly 16 accepted reads.
- R4: Each fetched word is taken as big-endian: the byte at the lowest address sits in bits 31:24. Each block applies one SHA-1 compression to the chaining words, so hashing the padded message "abc" from the standard state yields a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.
- R5: When a job ends, the address register has advanced by 64 bytes per block processed, and status bit 31 reads 0.
- R6: Blocks within one job are processed in address order, and each block starts from the chaining state left by the previous one.
- R7: While busy, writes to the address and chaining registers are ignored.
- R8: Writing 0x00000000 to offset 0x00 stops any job at once, clears busy, ends memory requests and loads the standard initial values into the chaining registers.
- R9: A job may start from chaining values written by software, and a second job issued without reloading continues from the advanced address and the updated state.
- R10: A command write with bit 31 clear and a nonzero value is ignored. A start command issued while busy is also ignored.
- R11: Each accepted read moves the memory address on by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory read request, held until accepted |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Request accepted; mem_rdata valid this cycle |
| mem_rdata | input | 32 | Read data, lowest-addressed byte in bits 31:24 |

## Verification
The hardest state to reach from the ports is a register write landing while the engine is partway through a job: a start, an init or address write, or the stop command arriving mid-fetch or mid-round. The bench holds off the memory model's acknowledges on a fixed pattern, so every job runs for a predictable span of cycles. It issues those writes right after a start, then checks that the address and chaining values match a job that ran undisturbed. It also checks that the stop command leaves no further reads behind. The bench runs jobs of 1 to 256 blocks and compares each result with its own SHA-1 model, including the known digest of "abc".

// File: rtl/sha1_dma.sv
module sha1_dma #(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);

  localparam logic [31:0] IV0 = 32'h67452301;
  localparam logic [31:0] IV1 = 32'hEFCDAB89;
  localparam logic [31:0] IV2 = 32'h98BADCFE;
  localparam logic [31:0] IV3 = 32'h10325476;
  localparam logic [31:0] IV4 = 32'hC3D2E1F0;
  localparam int          LAST_RND = 79;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ROUND, S_ADD} st_e;

  st_e              state;
  logic [31:0]      h_q [5];
  logic [31:0]      w_q [16];
  logic [31:0]      a_q, b_q, c_q, d_q, e_q;
  logic [31:0]      addr_q;
  logic [6:0]       rnd;
  logic [3:0]       widx;
  logic [CNT_W-1:0] blk_left;

  logic        busy, add_phase;
  logic        cmd_wr, abort, start;
  logic [3:0]  r4;
  logic [31:0] wt, wx, f, k, tmp;

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  assign busy      = (state != S_IDLE);
  assign add_phase = (state == S_ADD);
  assign mem_req   = (state == S_FETCH);
  assign mem_addr  = addr_q;

  assign cmd_wr = reg_we && (reg_addr == 5'h00);
  assign abort  = cmd_wr && (reg_wdata == 32'h0);
  assign start  = cmd_wr && reg_wdata[31] && !busy;

  assign r4 = rnd[3:0];
  assign wx = rotl(w_q[4'(r4 + 4'd13)] ^ w_q[4'(r4 + 4'd8)] ^
                   w_q[4'(r4 + 4'd2)]  ^ w_q[r4], 1);
  assign wt = (rnd < 7'd16) ? w_q[r4] : wx;

  always_comb begin
    if (rnd < 7'd20) begin
      f = (b_q & c_q) | (~b_q & d_q);
      k = 32'h5A827999;
    end else if (rnd < 7'd40) begin
      f = b_q ^ c_q ^ d_q;
      k = 32'h6ED9EBA1;
    end else if (rnd < 7'd60) begin
      f = (b_q & c_q) | (b_q & d_q) | (c_q & d_q);
      k = 32'h8F1BBCDC;
    end else begin
      f = b_q ^ c_q ^ d_q;
      k = 32'hCA62C1D6;
    end
  end

  assign tmp = rotl(a_q, 5) + f + e_q + k + wt;

  always_comb begin
    case (reg_addr)
      5'h00:   reg_rdata = {busy, 31'h0};
      5'h04:   reg_rdata = addr_q;
      5'h08:   reg_rdata = h_q[0];
      5'h0C:   reg_rdata = h_q[1];
      5'h10:   reg_rdata = h_q[2];
      5'h14:   reg_rdata = h_q[3];
      5'h18:   reg_rdata = h_q[4];
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      h_q[0]   <= IV0;
      h_q[1]   <= IV1;
      h_q[2]   <= IV2;
      h_q[3]   <= IV3;
      h_q[4]   <= IV4;
      addr_q   <= 32'h0;
      rnd      <= 7'd0;
      widx     <= 4'd0;
      blk_left <= '0;
      a_q      <= 32'h0;
      b_q      <= 32'h0;
      c_q      <= 32'h0;
      d_q      <= 32'h0;
      e_q      <= 32'h0;
      for (int i = 0; i < 16; i++) w_q[i] <= 32'h0;
    end else if (abort) begin
      state  <= S_IDLE;
      h_q[0] <= IV0;
      h_q[1] <= IV1;
      h_q[2] <= IV2;
      h_q[3] <= IV3;
      h_q[4] <= IV4;
    end else begin
      case (state)
        S_IDLE: begin
          if (reg_we && reg_addr == 5'h04) addr_q <= reg_wdata;
          for (int i = 0; i < 5; i++)
            if (reg_we && reg_addr == 5'(8 + 4 * i)) h_q[i] <= reg_wdata;
          if (start) begin
            blk_left <= reg_wdata[CNT_W-1:0];
            widx     <= 4'd0;
            state    <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            w_q[widx] <= mem_rdata;
            addr_q    <= addr_q + 32'd4;
            widx      <= widx + 4'd1;
            if (widx == 4'd15) begin
              a_q   <= h_q[0];
              b_q   <= h_q[1];
              c_q   <= h_q[2];
              d_q   <= h_q[3];
              e_q   <= h_q[4];
              rnd   <= 7'd0;
              state <= S_ROUND;
            end
          end
        end
        S_ROUND: begin
          if (rnd >= 7'd16) w_q[r4] <= wx;
          e_q <= d_q;
          d_q <= c_q;
          c_q <= rotl(b_q, 30);
          b_q <= a_q;
          a_q <= tmp;
          rnd <= rnd + 7'd1;
          if (rnd == 7'(LAST_RND)) state <= S_ADD;
        end
        S_ADD: begin
          h_q[0] <= h_q[0] + a_q;
          h_q[1] <= h_q[1] + b_q;
          h_q[2] <= h_q[2] + c_q;
          h_q[3] <= h_q[3] + d_q;
          h_q[4] <= h_q[4] + e_q;
          if (blk_left == '0) begin
            state <= S_IDLE;
          end else begin
            blk_left <= blk_left - 1'b1;
            widx     <= 4'd0;
            state    <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sha1_dma_chk.sv
module sha1_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [4:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        busy,
  input logic        add_phase,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] h0
);

  logic stop_cmd;
  assign stop_cmd = reg_we && reg_addr == 5'h00 && reg_wdata == 32'h0;

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && reg_addr == 5'h00 && reg_wdata[31]) |=> busy);

  assert_req_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_addr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !stop_cmd) |=> mem_addr == $past(mem_addr) + 32'd4);

  assert_init_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !add_phase && !stop_cmd) |=> h0 == $past(h0));

  assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> (!busy && !mem_req && h0 == 32'h67452301));

  assert_nonstart_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && reg_addr == 5'h00 && !reg_wdata[31]) |=> !busy);

endmodule

bind sha1_dma sha1_dma_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .busy      (busy),
  .add_phase (add_phase),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .h0        (h_q[0])
);

// File: tb/sha1_dma_tb.sv
`timescale 1ns/1ps
module sha1_dma_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = 5'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = 32'h0;

  int nchk = 0;
  int nfail = 0;
  int acks = 0;
  logic [1:0] stall = 2'd0;
  logic [31:0] eh [5];

  localparam logic [31:0] IV [5] = '{32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                                     32'h10325476, 32'hC3D2E1F0};

  // {start address, fresh state flag, count field}
  localparam logic [63:0] VEC [5] = '{
    {32'h0000_2000, 1'b1, 23'h0, 8'h00},
    {32'h0000_2040, 1'b0, 23'h0, 8'h03},
    {32'h0000_8000, 1'b1, 23'h0, 8'h1F},
    {32'h0000_3000, 1'b0, 23'h0, 8'h01},
    {32'h0001_0000, 1'b1, 23'h0, 8'hFF}
  };

  always #10 clk = ~clk;

  sha1_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] memword(input logic [31:0] a);
    if (a >= 32'h1000 && a < 32'h1040) begin
      if (a == 32'h1000) return 32'h61626380;
      if (a == 32'h103C) return 32'h00000018;
      return 32'h0;
    end
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F ^ (a >> 7);
  endfunction

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic void ref_block(input logic [31:0] base);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) w[i] = memword(base + 32'(4 * i));
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    a = eh[0]; b = eh[1]; c = eh[2]; d = eh[3]; e = eh[4];
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      t = rl(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    eh[0] += a; eh[1] += b; eh[2] += c; eh[3] += d; eh[4] += e;
  endfunction

  // Memory model: acknowledges three cycles of every four
  always @(negedge clk) begin
    stall = stall + 2'd1;
    mem_ack = rst_n && mem_req && (stall != 2'b11);
    mem_rdata = memword(mem_addr);
    if (mem_ack) acks++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    int n = 0;
    do begin
      rd(5'h00, s);
      n++;
    end while (s[31] && n < 60000);
    chk({tag, " busy clears"}, {31'h0, s[31]}, 32'h0);
  endtask

  task automatic check_hash(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 5; i++) begin
      rd(5'(8 + 4 * i), v);
      chk(tag, v, eh[i]);
    end
  endtask

  task automatic run_model(input logic [31:0] base, input int n);
    for (int b = 0; b < n; b++) ref_block(base + 32'(64 * b));
  endtask

  task automatic fresh();
    wr(5'h00, 32'h0);
    for (int i = 0; i < 5; i++) eh[i] = IV[i];
  endtask

  initial begin
    #(20 * 190000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v, a0;
    int n, a_snap;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h00, v); chk("R1 status", v, 32'h0);
    rd(5'h04, v); chk("R1 address", v, 32'h0);
    for (int i = 0; i < 5; i++) eh[i] = IV[i];
    check_hash("R1 init words");

    // R4 known digest of "abc"
    wr(5'h04, 32'h1000);
    acks = 0;
    wr(5'h00, 32'h8000_0000);
    rd(5'h00, v); chk("R2 busy after start", v, 32'h8000_0000);
    wait_idle("R5");
    eh[0] = 32'ha9993e36; eh[1] = 32'h4706816a; eh[2] = 32'hba3e2571;
    eh[3] = 32'h7850c26c; eh[4] = 32'h9cd0d89d;
    check_hash("R4 abc digest");
    rd(5'h04, v); chk("R5 address advance", v, 32'h1040);
    chk("R3 reads per block", 32'(acks), 32'd16);

    // Table of jobs: R3 R5 R6
    for (int j = 0; j < 5; j++) begin
      a0 = VEC[j][63:32];
      n  = int'(VEC[j][7:0]) + 1;
      if (VEC[j][31]) fresh();
      wr(5'h04, a0);
      acks = 0;
      wr(5'h00, 32'h8000_0000 | {24'h0, VEC[j][7:0]});
      run_model(a0, n);
      wait_idle("R5 table");
      check_hash("R6 table digest");
      rd(5'h04, v); chk("R5 table address", v, a0 + 32'(64 * n));
      chk("R3 table read count", 32'(acks), 32'(16 * n));
    end

    // R7 and R10: writes during a job are ignored
    fresh();
    wr(5'h04, 32'h4000);
    acks = 0;
    wr(5'h00, 32'h8000_0001);
    wr(5'h08, 32'h0);
    wr(5'h04, 32'hDEAD_0000);
    wr(5'h00, 32'h8000_0007);
    wr(5'h18, 32'h1234_5678);
    run_model(32'h4000, 2);
    wait_idle("R7");
    check_hash("R7 init writes ignored while busy");
    rd(5'h04, v); chk("R7 address write ignored", v, 32'h4080);
    chk("R10 start while busy ignored", 32'(acks), 32'd32);

    // R10: nonzero command without bit 31 is ignored
    acks = 0;
    wr(5'h00, 32'h0000_0003);
    rd(5'h00, v); chk("R10 status stays idle", v, 32'h0);
    repeat (20) @(negedge clk);
    chk("R10 no reads", 32'(acks), 32'd0);
    check_hash("R10 state unchanged");
    rd(5'h04, v); chk("R10 address unchanged", v, 32'h4080);

    // R9: software-loaded state, then continuation without reload
    eh[0] = 32'h0123_4567; eh[1] = 32'h89AB_CDEF; eh[2] = 32'hFEDC_BA98;
    eh[3] = 32'h7654_3210; eh[4] = 32'hF0E1_D2C3;
    for (int i = 0; i < 5; i++) wr(5'(8 + 4 * i), eh[i]);
    wr(5'h04, 32'h5000);
    wr(5'h00, 32'h8000_0000);
    run_model(32'h5000, 1);
    wait_idle("R9");
    check_hash("R9 custom state");
    wr(5'h00, 32'h8000_0000);
    run_model(32'h5040, 1);
    wait_idle("R9");
    check_hash("R9 continued job");
    rd(5'h04, v); chk("R9 continued address", v, 32'h5080);

    // R8: stop command mid-job
    wr(5'h04, 32'h6000);
    wr(5'h00, 32'h8000_0010);
    repeat (40) @(negedge clk);
    wr(5'h00, 32'h0);
    rd(5'h00, v); chk("R8 busy cleared", v, 32'h0);
    for (int i = 0; i < 5; i++) eh[i] = IV[i];
    check_hash("R8 standard values reloaded");
    a_snap = acks;
    repeat (50) @(negedge clk);
    chk("R8 no reads after stop", 32'(acks), 32'(a_snap));
    chk("R8 request low", {31'h0, mem_req}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule